// File: doc/BRIEF.md
# Memory Test Access Port

This block is the boundary-scan test port of a synchronous memory device. It is clocked by the test clock, follows the test-mode select line through the standard sixteen-state controller, and offers a serial path from the test data input to the test data output. The path can run through a 3-bit instruction register, a one-bit bypass stage, a 32-bit device identification register or an external boundary-scan chain. The chain's cells live outside this block. The port only supplies them with serial data, receives their serial output, and gives them capture, shift and update strobes.

No reset pin belongs to the test interface. The `por_i` input models the device's own power-up event and drives the controller into Test-Logic-Reset. Any input that reads as neither 0 nor 1 on the mode or data line counts as a 1. The instruction decode also drives `dq_hiz_o`, which tells the memory's data pins to float while pin values are sampled. No instruction ever connects the memory array to the test output.

Top module: `mem_tap`

## Requirements
- R1: While `por_i` is high and after its release, the controller sits in Test-Logic-Reset. The active instruction is IDCODE, `tdo_oe_o` is 0, `dq_hiz_o` is 0, and all three boundary strobes are 0.
- R2: The controller follows the standard sixteen-state TMS transition graph on rising TCK. Five consecutive rising edges with TMS=1 reach Test-Logic-Reset from any state, which reloads IDCODE.
- R3: The instruction register shifts least significant bit first, with TDI entering bit 2. Capture-IR loads 3'b001, so the first three bits out are 1, 0, 0. The new instruction takes effect only on the falling edge in Update-IR and not earlier, for example in Exit1-IR.
- R4: Instruction codes are 000 EXTEST, 001 IDCODE, 010 SAMPLE-Z, 011 BYPASS and 100 SAMPLE. Codes 101, 110 and 111 act as BYPASS.
- R5: `dq_hiz_o` is 1 exactly while the active instruction is EXTEST or SAMPLE-Z. SAMPLE leaves it 0.
- R6: Under IDCODE, Capture-DR loads the ID parameter (bit 0 = 1), which shifts out least significant bit first. TDI enters bit 31, so input data reappears at TDO 32 shifts later.
- R7: Under BYPASS, Capture-DR clears the bypass stage, so the first bit out is 0. After that, TDO repeats TDI with exactly one shift of delay.
- R8: Under EXTEST, SAMPLE-Z and SAMPLE, TDO in Shift-DR follows `bsr_tdo_i`, and the strobes `bsr_capture_o`, `bsr_shift_o` and `bsr_update_o` are 1 in Capture-DR, Shift-DR and Update-DR. Under any other instruction they stay 0.
- R9: TDO and its enable change only on falling TCK. `tdo_oe_o` is 1 only in Shift-DR and Shift-IR.
- R10: Passing Exit1-DR, Pause-DR and Exit2-DR, then returning to Shift-DR, keeps the data register contents. Shifting resumes with the next bit. The same holds for the IR column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| por_i | input | 1 | Power-up reset, synchronous, active high |
| tms_i | input | 1 | Test mode select (undriven reads as 1) |
| tdi_i | input | 1 | Test data in (undriven reads as 1) |
| tdo_o | output | 1 | Test data out, updated on falling TCK |
| tdo_oe_o | output | 1 | Output enable for tdo_o |
| dq_hiz_o | output | 1 | Float the memory data pins |
| bsr_tdi_o | output | 1 | Serial data into the boundary chain |
| bsr_tdo_i | input | 1 | Serial data from the boundary chain |
| bsr_capture_o | output | 1 | Boundary chain capture strobe |
| bsr_shift_o | output | 1 | Boundary chain shift strobe |
| bsr_update_o | output | 1 | Boundary chain update strobe |

## Verification
The bench loads every one of the eight instruction codes. For each it checks the data-pin float flag and which register the two-bit scan goes through. A decoder that let the spare codes reach the ID or boundary path shows the wrong first bits, and one that floated the pins for SAMPLE raises `dq_hiz_o`. Early instruction activation is caught by looking at the float flag in Exit1-IR. TDO launched on the rising edge is caught by sampling between the edges. The pause round trip exposes a register that shifts or recaptures while parked. Forcing reset with five TMS highs from inside the DR and IR shift states catches a controller with a wrong escape arc.

// File: rtl/mem_tap_pkg.sv
`timescale 1ns/1ps
package mem_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR    = 4'h0,
    ST_RTI    = 4'h1,
    ST_SELDR  = 4'h2,
    ST_CAPDR  = 4'h3,
    ST_SHDR   = 4'h4,
    ST_EX1DR  = 4'h5,
    ST_PAUDR  = 4'h6,
    ST_EX2DR  = 4'h7,
    ST_UPDDR  = 4'h8,
    ST_SELIR  = 4'h9,
    ST_CAPIR  = 4'hA,
    ST_SHIR   = 4'hB,
    ST_EX1IR  = 4'hC,
    ST_PAUIR  = 4'hD,
    ST_EX2IR  = 4'hE,
    ST_UPDIR  = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BSR = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BYP = 2'd2
  } dr_path_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b011;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] IR_CAP_PAT = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      ST_TLR:   n = m ? ST_TLR   : ST_RTI;
      ST_RTI:   n = m ? ST_SELDR : ST_RTI;
      ST_SELDR: n = m ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: n = m ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  n = m ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: n = m ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: n = m ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: n = m ? ST_UPDDR : ST_SHDR;
      ST_UPDDR: n = m ? ST_SELDR : ST_RTI;
      ST_SELIR: n = m ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: n = m ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  n = m ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: n = m ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: n = m ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: n = m ? ST_UPDIR : ST_SHIR;
      ST_UPDIR: n = m ? ST_SELDR : ST_RTI;
      default:  n = ST_TLR;
    endcase
    return n;
  endfunction

  function automatic dr_path_e op_path(input logic [IR_W-1:0] op);
    dr_path_e p;
    case (op)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: p = PATH_BSR;
      OP_IDCODE:                        p = PATH_ID;
      default:                          p = PATH_BYP;
    endcase
    return p;
  endfunction

  function automatic logic op_floats_pins(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
  endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import mem_tap_pkg::*;
#(
  parameter int ESC_LEN = 5
) (
  input  logic       tck,
  input  logic       por,
  input  logic       tms,
  output tap_state_e st
);
  localparam int CNT_W = $clog2(ESC_LEN + 1);

  always_ff @(posedge tck) begin
    if (por) st <= ST_TLR;
    else     st <= tap_next(st, tms);
  end

  // Run of consecutive TMS highs, used by the escape-path check.
  logic [CNT_W-1:0] ones_cnt;
  always_ff @(posedge tck) begin
    if (por || !tms)                         ones_cnt <= '0;
    else if (ones_cnt != CNT_W'(ESC_LEN))    ones_cnt <= ones_cnt + 1'b1;
  end

  p_por_to_reset_r1: assert property (@(posedge tck) por |=> st == ST_TLR);

  p_tms_escape_r2: assert property (@(posedge tck) disable iff (por)
    ones_cnt == CNT_W'(ESC_LEN) |-> st == ST_TLR);

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import mem_tap_pkg::*;
#(
  parameter logic [IR_W-1:0] CAP_PAT = IR_CAP_PAT,
  parameter logic [IR_W-1:0] RST_OP  = OP_IDCODE
) (
  input  logic            tck,
  input  logic            por,
  input  logic            tdi,
  input  tap_state_e      st,
  output logic            ir_lsb,
  output logic [IR_W-1:0] instr
);
  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (por || st == ST_CAPIR) ir_sh <= CAP_PAT;
    else if (st == ST_SHIR)    ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_ff @(negedge tck) begin
    if (por || st == ST_TLR)  instr <= RST_OP;
    else if (st == ST_UPDIR)  instr <= ir_sh;
  end

  assign ir_lsb = ir_sh[0];

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (por)
    st == ST_CAPIR |=> ir_sh == CAP_PAT);

  p_ir_hold_r3: assert property (@(negedge tck) disable iff (por)
    !(st == ST_UPDIR || st == ST_TLR) |=> $stable(instr));

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import mem_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E6D
) (
  input  logic       tck,
  input  logic       por,
  input  logic       tdi,
  input  tap_state_e st,
  input  dr_path_e   path,
  input  logic       bsr_tdo,
  output logic       dr_bit
);
  logic [ID_W-1:0] id_sh;
  logic            byp;

  always_ff @(posedge tck) begin
    if (por) begin
      id_sh <= ID_VALUE;
      byp   <= 1'b0;
    end else begin
      case (st)
        ST_CAPDR: begin
          if (path == PATH_ID)  id_sh <= ID_VALUE;
          if (path == PATH_BYP) byp   <= 1'b0;
        end
        ST_SHDR: begin
          if (path == PATH_ID)  id_sh <= {tdi, id_sh[ID_W-1:1]};
          if (path == PATH_BYP) byp   <= tdi;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (path)
      PATH_ID:  dr_bit = id_sh[0];
      PATH_BYP: dr_bit = byp;
      default:  dr_bit = bsr_tdo;
    endcase
  end

  p_id_capture_r6: assert property (@(posedge tck) disable iff (por)
    (st == ST_CAPDR && path == PATH_ID) |=> id_sh == ID_VALUE);

  p_bypass_clear_r7: assert property (@(posedge tck) disable iff (por)
    (st == ST_CAPDR && path == PATH_BYP) |=> !byp);

  p_id_parks_r10: assert property (@(posedge tck) disable iff (por)
    (st == ST_PAUDR || st == ST_EX2DR) |=> $stable(id_sh));

endmodule

// File: rtl/mem_tap.sv
`timescale 1ns/1ps
module mem_tap
  import mem_tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E6D
) (
  input  logic tck_i,
  input  logic por_i,
  input  logic tms_i,
  input  logic tdi_i,
  output logic tdo_o,
  output logic tdo_oe_o,
  output logic dq_hiz_o,
  output logic bsr_tdi_o,
  input  logic bsr_tdo_i,
  output logic bsr_capture_o,
  output logic bsr_shift_o,
  output logic bsr_update_o
);
  // An input that is not a clean 0 counts as 1.
  logic tms_c, tdi_c;
  assign tms_c = (tms_i !== 1'b0);
  assign tdi_c = (tdi_i !== 1'b0);

  tap_state_e      st;
  logic            ir_lsb;
  logic [IR_W-1:0] instr;
  dr_path_e        path;
  logic            dr_bit;
  logic            bsr_sel;

  tap_fsm #(.ESC_LEN(5)) u_fsm (
    .tck (tck_i),
    .por (por_i),
    .tms (tms_c),
    .st  (st)
  );

  tap_ir #(.CAP_PAT(IR_CAP_PAT), .RST_OP(OP_IDCODE)) u_ir (
    .tck    (tck_i),
    .por    (por_i),
    .tdi    (tdi_c),
    .st     (st),
    .ir_lsb (ir_lsb),
    .instr  (instr)
  );

  assign path    = op_path(instr);
  assign bsr_sel = (path == PATH_BSR);

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck     (tck_i),
    .por     (por_i),
    .tdi     (tdi_c),
    .st      (st),
    .path    (path),
    .bsr_tdo (bsr_tdo_i),
    .dr_bit  (dr_bit)
  );

  assign dq_hiz_o      = op_floats_pins(instr);
  assign bsr_tdi_o     = tdi_c;
  assign bsr_capture_o = bsr_sel && (st == ST_CAPDR);
  assign bsr_shift_o   = bsr_sel && (st == ST_SHDR);
  assign bsr_update_o  = bsr_sel && (st == ST_UPDDR);

  // Output stage launches on the falling edge.
  logic tdo_q, oe_q;
  always_ff @(negedge tck_i) begin
    if (por_i) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= (st == ST_SHDR) || (st == ST_SHIR);
      if (st == ST_SHIR)      tdo_q <= ir_lsb;
      else if (st == ST_SHDR) tdo_q <= dr_bit;
    end
  end
  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;

  p_oe_in_shift_r9: assert property (@(posedge tck_i) disable iff (por_i)
    tdo_oe_o |-> (st == ST_SHDR || st == ST_SHIR));

  p_sample_keeps_pins_r5: assert property (@(posedge tck_i) disable iff (por_i)
    instr == OP_SAMPLE |-> !dq_hiz_o);

  p_spare_codes_bypass_r4: assert property (@(posedge tck_i) disable iff (por_i)
    instr > OP_SAMPLE |-> !(bsr_capture_o || bsr_shift_o || bsr_update_o));

endmodule

// File: tb/mem_tap_tb_top.sv
`timescale 1ns/1ps
module mem_tap_tb_top;
  localparam logic [31:0] ID = 32'h1A5C_3E6D;

  logic clk = 1'b0;
  logic por = 1'b1, tms = 1'b1, tdi = 1'b0, bsr_tdo = 1'b0;
  logic tdo, tdo_oe, dq_hiz, bsr_tdi, bcap, bsh, bupd;

  always #5 clk = ~clk;

  mem_tap #(.ID_W(32), .ID_VALUE(ID)) dut_i (
    .tck_i(clk), .por_i(por), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_oe_o(tdo_oe), .dq_hiz_o(dq_hiz),
    .bsr_tdi_o(bsr_tdi), .bsr_tdo_i(bsr_tdo),
    .bsr_capture_o(bcap), .bsr_shift_o(bsh), .bsr_update_o(bupd)
  );

  int checks = 0, errs = 0;
  logic [63:0] bsr_pat = '0;
  logic cap_seen, sh_seen, upd_seen, hiz_mid;
  int oe_bad;

  // {code[2:0], float, boundary, expected out[1:0]} for two shifts of TDI=1, chain=0
  localparam logic [6:0] VEC [8] = '{
    7'b000_1_1_00, 7'b001_0_0_01, 7'b010_1_1_00, 7'b011_0_0_10,
    7'b100_0_1_00, 7'b101_0_0_10, 7'b110_0_0_10, 7'b111_0_0_10
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic dr_scan(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0; oe_bad = 0;
    step(1, 0); step(0, 0);
    cap_seen = bcap;
    bsr_tdo = bsr_pat[0];
    step(0, 0);
    sh_seen = bsh;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (!tdo_oe) oe_bad++;
      if (i < 63) bsr_tdo = bsr_pat[i+1];
      step(i == n-1, din[i]);
    end
    step(1, 0);
    upd_seen = bupd;
    step(0, 0);
  endtask

  task automatic ir_scan(input logic [2:0] code, output logic [2:0] capv);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      capv[i] = tdo;
      step(i == 2, code[i]);
    end
    hiz_mid = dq_hiz;
    step(1, 0); step(0, 0);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] o;
    logic [2:0] c;
    repeat (3) @(posedge clk);
    @(negedge clk); #1; por = 1'b0;
    // R1 reset state
    chk("R1 oe after power-up", {63'd0, tdo_oe}, 64'd0);
    chk("R1 float after power-up", {63'd0, dq_hiz}, 64'd0);
    chk("R1 strobes after power-up", {61'd0, bcap, bsh, bupd}, 64'd0);
    step(0, 0);

    // R6 default IDCODE read, then serial pass-through
    dr_scan(32, 64'd0, o);
    chk("R1 R6 ID read after reset", o, {32'd0, ID});
    chk("R9 oe high throughout shift", oe_bad, 0);
    dr_scan(64, {32'd0, 32'hC3A5_0F96}, o);
    chk("R6 32-shift delay", o, {32'hC3A5_0F96, ID});

    // R3 capture pattern and late activation; R5 float flag
    ir_scan(3'b000, c);
    chk("R3 IR capture pattern", c, 3'b001);
    chk("R3 no effect before Update-IR", hiz_mid, 1'b0);
    chk("R5 EXTEST floats pins", dq_hiz, 1'b1);

    // R4 R5 R8 table walk over all codes
    for (int k = 0; k < 8; k++) begin
      ir_scan(VEC[k][6:4], c);
      chk("R3 capture in table", c, 3'b001);
      chk("R4 R5 float per code", dq_hiz, VEC[k][3]);
      bsr_pat = '0;
      dr_scan(2, 64'h3, o);
      chk("R4 path per code", o[1:0], VEC[k][1:0]);
      chk("R8 strobes per code", {cap_seen, sh_seen, upd_seen}, {3{VEC[k][2]}});
    end

    // R8 chain data routed under SAMPLE
    ir_scan(3'b100, c);
    bsr_pat = 64'h0000_0000_0000_B6D1;
    dr_scan(16, 64'd0, o);
    chk("R8 chain output at TDO", o[15:0], 16'hB6D1);
    chk("R5 SAMPLE keeps pins driven", dq_hiz, 1'b0);
    bsr_pat = '0; bsr_tdo = 1'b0;

    // R7 bypass delay
    ir_scan(3'b011, c);
    dr_scan(16, 64'h0000_0000_0000_B2C5, o);
    chk("R7 bypass one-shift delay", o[15:0], 16'h658A);

    // R9 falling-edge launch and R10 pause round trip (still BYPASS)
    step(1, 0); step(0, 0);
    tms = 0; @(posedge clk); #1;
    chk("R9 oe unchanged at rising edge", tdo_oe, 1'b0);
    @(negedge clk); #1;
    chk("R9 oe rises at falling edge", tdo_oe, 1'b1);
    chk("R7 first bypass bit", tdo, 1'b0);
    step(0, 1);
    chk("R7 bypass bit one", tdo, 1'b1);
    step(1, 0);
    step(0, 1); step(0, 1);
    chk("R10 oe low in pause", tdo_oe, 1'b0);
    step(1, 1); step(0, 1);
    chk("R10 resumed shift keeps bit", tdo, 1'b0);
    chk("R10 oe back in shift", tdo_oe, 1'b1);
    step(1, 0); step(1, 0); step(0, 0);

    // R10 IR pause path loading SAMPLE-Z
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 0); step(1, 1);
    step(0, 0); step(1, 0); step(0, 0);
    step(1, 0); step(1, 0); step(0, 0);
    chk("R10 IR pause keeps bits (SAMPLE-Z)", dq_hiz, 1'b1);
    dr_scan(1, 64'd0, o);
    chk("R10 SAMPLE-Z selects chain", cap_seen, 1'b1);

    // R2 escape to reset from Shift-DR
    ir_scan(3'b000, c);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R2 escape from Shift-DR", {tdo_oe, dq_hiz}, 2'b00);
    step(0, 0);
    // R2 escape from Shift-IR
    ir_scan(3'b010, c);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    chk("R2 escape from Shift-IR", {tdo_oe, dq_hiz}, 2'b00);
    step(0, 0);
    // R2 Select-IR to reset arc
    ir_scan(3'b000, c);
    step(1, 0); step(1, 0); step(1, 0);
    chk("R2 Select-IR exit to reset", dq_hiz, 1'b0);
    step(0, 0);
    dr_scan(32, 64'd0, o);
    chk("R2 IDCODE active after reset", o[31:0], ID);

    finish_run();
  end
endmodule